// File: doc/BRIEF.md
# Cacheable Access Blocking Filter

This filter sits in the request path between a system-bus request port and the controller of an external peripheral bus. Each region of the peripheral space has a block-cacheable enable bit. When a cacheable access arrives for a region whose bit is set, the filter keeps it off the external bus. The access still completes normally toward the requester, so an accidental speculative fetch into device space has no side effects and causes no error. Every other access is forwarded unchanged, one cycle later.

A blocked access leaves a quiet record. A status flag is set, and it clears when software reads the status register. The request address is also captured into a pair of log registers, low half and high half. Capture happens only while the shared error log is unlocked, which means the bus error interrupt is not asserted. The flag drives no interrupt.

Top module: `cache_blk_filter`

## Requirements
- R1: A request is blocked exactly when `req_valid`, `req_cacheable` and the enable bit selected by `req_region` are all 1. A region index at or above NREGION is never blocked.
- R2: All enable bits are 0 after reset, so every access passes. A cycle with `cfg_we`=1 loads `cfg_blk_en` into the enables from the next cycle on. A request in the same cycle uses the old enables.
- R3: A blocked request never produces `bus_valid`.
- R4: A blocked read raises `blk_rsp_valid` for one cycle, on the cycle after the request, with `blk_rsp_write`=0. It also drives `blk_rsp_code`=2'b00 (valid data; 2'b11 is the error code and is never used here) and `blk_rsp_data`=FILL_DATA.
- R5: A blocked write is acknowledged in the same way as a blocked read, with `blk_rsp_write`=1 and `blk_rsp_data`=0. Its data goes nowhere.
- R6: `stat_blk` becomes 1 on the cycle after a blocked request. It becomes 0 on the cycle after a `stat_rd` pulse that has no blocked request in the same cycle. Otherwise it holds.
- R7: A blocked request and `stat_rd` in the same cycle leave `stat_blk` at 1.
- R8: A blocked request with `err_lock`=0 loads the log registers on the next cycle. `log_lo` takes address bits [REG_W-1:0]. `log_hi` takes the address bits above them, zero-extended.
- R9: The log registers hold their value at all other times, including blocked requests that arrive while `err_lock`=1.
- R10: A request that is not blocked appears on the next cycle as `bus_valid`=1 with the same write flag, address, region and write data. `bus_valid` is 0 on any cycle with no such request.
- R11: After reset, `bus_valid`, `blk_rsp_valid`, `stat_blk`, `log_lo` and `log_hi` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the per-region enables |
| cfg_blk_en | input | NREGION | New block-cacheable enables, one bit per region |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cacheable | input | 1 | Request carries the cacheable attribute |
| req_addr | input | ADDR_W | Request address |
| req_region | input | RGN_W | Region index of the request |
| req_wdata | input | DATA_W | Write data |
| stat_rd | input | 1 | Status register is being read (clears the flag) |
| err_lock | input | 1 | Bus error interrupt asserted; freezes the log |
| bus_valid | output | 1 | Forwarded request to the external bus |
| bus_write | output | 1 | Forwarded write flag |
| bus_addr | output | ADDR_W | Forwarded address |
| bus_region | output | RGN_W | Forwarded region index |
| bus_wdata | output | DATA_W | Forwarded write data |
| blk_rsp_valid | output | 1 | Completion of a blocked access |
| blk_rsp_write | output | 1 | Completion belongs to a write |
| blk_rsp_code | output | 2 | Return code, always 2'b00 (valid data) |
| blk_rsp_data | output | DATA_W | Filler read data |
| stat_blk | output | 1 | Cacheable-blocked status flag |
| log_lo | output | REG_W | Logged address, low half |
| log_hi | output | REG_W | Logged address, high half |

## Verification
The hardest case to reach from the ports is a blocked request that lands in the same cycle as a status read. Another is a blocked request that arrives while the log is locked. Both need a region's enable set first through the configuration port, and then a cacheable request aimed at that exact region. Directed sequences program the enables and line up `stat_rd` and `err_lock` with a blocked request on the same edge. A long random phase then mixes regions, attributes, enable reloads, status reads and lock changes. The behavioural reference model compares every output on every cycle.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
   typedef enum logic [1:0] {
      RC_DATA_OK = 2'b00,
      RC_BUS_ERR = 2'b11
   } rsp_code_e;
endpackage

// File: rtl/cbf_en_reg.sv
module cbf_en_reg #(
   parameter int NREGION = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [NREGION-1:0] cfg_blk_en,
   output logic [NREGION-1:0] en_q
);
   for (genvar g = 0; g < NREGION; g++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)      en_q[g] <= 1'b0;
         else if (cfg_we) en_q[g] <= cfg_blk_en[g];
      end
   end
endmodule

// File: rtl/cbf_decide.sv
module cbf_decide #(
   parameter int RGN_W = 3,
   localparam int NPAD = 1 << RGN_W
) (
   input  logic             req_valid,
   input  logic             req_cacheable,
   input  logic [RGN_W-1:0] req_region,
   input  logic [NPAD-1:0]  en_pad,
   output logic             blocked,
   output logic             passed
);
   logic hit;
   always_comb begin
      hit     = req_cacheable && en_pad[req_region];
      blocked = req_valid && hit;
      passed  = req_valid && !hit;
   end
endmodule

// File: rtl/cbf_fwd.sv
module cbf_fwd
   import cbf_pkg::*;
#(
   parameter int          ADDR_W    = 40,
   parameter int          DATA_W    = 32,
   parameter int          RGN_W     = 3,
   parameter logic [DATA_W-1:0] FILL_DATA = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blocked,
   input  logic              passed,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [RGN_W-1:0]  req_region,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              bus_valid,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [RGN_W-1:0]  bus_region,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              blk_rsp_valid,
   output logic              blk_rsp_write,
   output logic [1:0]        blk_rsp_code,
   output logic [DATA_W-1:0] blk_rsp_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_valid  <= 1'b0;
         bus_write  <= 1'b0;
         bus_addr   <= '0;
         bus_region <= '0;
         bus_wdata  <= '0;
      end else begin
         bus_valid <= passed;
         if (passed) begin
            bus_write  <= req_write;
            bus_addr   <= req_addr;
            bus_region <= req_region;
            bus_wdata  <= req_wdata;
         end
      end
   end

   rsp_code_e code_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         blk_rsp_valid <= 1'b0;
         blk_rsp_write <= 1'b0;
         blk_rsp_data  <= '0;
         code_q        <= RC_DATA_OK;
      end else begin
         blk_rsp_valid <= blocked;
         if (blocked) begin
            blk_rsp_write <= req_write;
            blk_rsp_data  <= req_write ? '0 : FILL_DATA;
            code_q        <= RC_DATA_OK;
         end
      end
   end
   assign blk_rsp_code = code_q;
endmodule

// File: rtl/cbf_log.sv
module cbf_log #(
   parameter int ADDR_W = 40,
   parameter int REG_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blocked,
   input  logic              stat_rd,
   input  logic              err_lock,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              stat_blk,
   output logic [REG_W-1:0]  log_lo,
   output logic [REG_W-1:0]  log_hi
);
   logic [REG_W-1:0] lo_part, hi_part;

   if (ADDR_W >= REG_W) begin : g_lo_slice
      assign lo_part = req_addr[REG_W-1:0];
   end else begin : g_lo_ext
      assign lo_part = REG_W'(req_addr);
   end

   if (ADDR_W > REG_W) begin : g_hi_slice
      assign hi_part = REG_W'(req_addr[ADDR_W-1:REG_W]);
   end else begin : g_hi_zero
      assign hi_part = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       stat_blk <= 1'b0;
      else if (blocked) stat_blk <= 1'b1;
      else if (stat_rd) stat_blk <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         log_lo <= '0;
         log_hi <= '0;
      end else if (blocked && !err_lock) begin
         log_lo <= lo_part;
         log_hi <= hi_part;
      end
   end
endmodule

// File: rtl/cache_blk_filter.sv
module cache_blk_filter #(
   parameter int                ADDR_W    = 40,
   parameter int                DATA_W    = 32,
   parameter int                REG_W     = 32,
   parameter int                NREGION   = 8,
   parameter int                RGN_W     = 3,
   parameter logic [DATA_W-1:0] FILL_DATA = 32'hDEAD_BEEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [NREGION-1:0] cfg_blk_en,
   input  logic               req_valid,
   input  logic               req_write,
   input  logic               req_cacheable,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [RGN_W-1:0]   req_region,
   input  logic [DATA_W-1:0]  req_wdata,
   input  logic               stat_rd,
   input  logic               err_lock,
   output logic               bus_valid,
   output logic               bus_write,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [RGN_W-1:0]   bus_region,
   output logic [DATA_W-1:0]  bus_wdata,
   output logic               blk_rsp_valid,
   output logic               blk_rsp_write,
   output logic [1:0]         blk_rsp_code,
   output logic [DATA_W-1:0]  blk_rsp_data,
   output logic               stat_blk,
   output logic [REG_W-1:0]   log_lo,
   output logic [REG_W-1:0]   log_hi
);
   localparam int NPAD = 1 << RGN_W;

   if (NREGION < 1 || NREGION > NPAD) begin : g_bad_rgn
      $error("NREGION must lie in 1..2**RGN_W");
   end
   if (ADDR_W > 2 * REG_W || ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must fit in two log registers");
   end
   if (RGN_W < 1 || RGN_W > 8) begin : g_bad_rw
      $error("RGN_W out of range");
   end

   logic [NREGION-1:0] blk_en_q;
   logic [NPAD-1:0]    en_pad;
   logic               blocked, passed;

   cbf_en_reg #(.NREGION(NREGION)) u_en (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
      .cfg_blk_en(cfg_blk_en), .en_q(blk_en_q));

   if (NREGION == NPAD) begin : g_full
      assign en_pad = blk_en_q;
   end else begin : g_pad
      assign en_pad = {{(NPAD-NREGION){1'b0}}, blk_en_q};
   end

   cbf_decide #(.RGN_W(RGN_W)) u_dec (
      .req_valid(req_valid), .req_cacheable(req_cacheable),
      .req_region(req_region), .en_pad(en_pad),
      .blocked(blocked), .passed(passed));

   cbf_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RGN_W(RGN_W),
             .FILL_DATA(FILL_DATA)) u_fwd (
      .clk(clk), .rst_n(rst_n), .blocked(blocked), .passed(passed),
      .req_write(req_write), .req_addr(req_addr),
      .req_region(req_region), .req_wdata(req_wdata),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_region(bus_region), .bus_wdata(bus_wdata),
      .blk_rsp_valid(blk_rsp_valid), .blk_rsp_write(blk_rsp_write),
      .blk_rsp_code(blk_rsp_code), .blk_rsp_data(blk_rsp_data));

   cbf_log #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_log (
      .clk(clk), .rst_n(rst_n), .blocked(blocked), .stat_rd(stat_rd),
      .err_lock(err_lock), .req_addr(req_addr),
      .stat_blk(stat_blk), .log_lo(log_lo), .log_hi(log_hi));
endmodule

// File: rtl/cbf_chk.sv
module cbf_chk #(
   parameter int ADDR_W = 40,
   parameter int REG_W  = 32,
   parameter int RGN_W  = 3,
   localparam int NPAD  = 1 << RGN_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic              req_cacheable,
   input logic [ADDR_W-1:0] req_addr,
   input logic [RGN_W-1:0]  req_region,
   input logic [NPAD-1:0]   en_pad,
   input logic              stat_rd,
   input logic              err_lock,
   input logic              bus_valid,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              blk_rsp_valid,
   input logic              blk_rsp_write,
   input logic [1:0]        blk_rsp_code,
   input logic              stat_blk,
   input logic [REG_W-1:0]  log_lo,
   input logic [REG_W-1:0]  log_hi
);
   logic hit_c;
   assign hit_c = req_valid && req_cacheable && en_pad[req_region];

   assert_blocked_no_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit_c |=> !bus_valid);
   assert_pass_forward_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hit_c) |=> (bus_valid && bus_addr == $past(req_addr)));
   assert_blocked_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
      hit_c |=> (blk_rsp_valid && blk_rsp_code == 2'b00));
   assert_ack_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit_c |=> (blk_rsp_write == $past(req_write)));
   assert_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && blk_rsp_valid));
   assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !hit_c) |=> !stat_blk);
   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hit_c |=> stat_blk);
   assert_log_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_c && !err_lock) |=> ($stable(log_lo) && $stable(log_hi)));
   assert_log_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_c && !err_lock) |=> (log_lo == $past(req_addr[REG_W-1:0])));
endmodule

bind cache_blk_filter cbf_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .RGN_W(RGN_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_cacheable(req_cacheable), .req_addr(req_addr), .req_region(req_region),
   .en_pad(en_pad), .stat_rd(stat_rd), .err_lock(err_lock),
   .bus_valid(bus_valid), .bus_addr(bus_addr), .blk_rsp_valid(blk_rsp_valid),
   .blk_rsp_write(blk_rsp_write), .blk_rsp_code(blk_rsp_code),
   .stat_blk(stat_blk), .log_lo(log_lo), .log_hi(log_hi));

// File: tb/sim_cache_blk_filter.sv
`timescale 1ns/1ps
module sim_cache_blk_filter;
   localparam int ADDR_W = 40, DATA_W = 32, REG_W = 32, NREGION = 8, RGN_W = 3;
   localparam logic [31:0] FILL = 32'hDEAD_BEEF;

   logic clk = 0, rst_n = 0;
   logic cfg_we = 0; logic [NREGION-1:0] cfg_blk_en = '0;
   logic req_valid = 0, req_write = 0, req_cacheable = 0;
   logic [ADDR_W-1:0] req_addr = '0; logic [RGN_W-1:0] req_region = '0;
   logic [DATA_W-1:0] req_wdata = '0;
   logic stat_rd = 0, err_lock = 0;
   logic bus_valid, bus_write, blk_rsp_valid, blk_rsp_write, stat_blk;
   logic [ADDR_W-1:0] bus_addr; logic [RGN_W-1:0] bus_region;
   logic [DATA_W-1:0] bus_wdata, blk_rsp_data; logic [1:0] blk_rsp_code;
   logic [REG_W-1:0] log_lo, log_hi;

   always #10 clk = ~clk;

   cache_blk_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
      .NREGION(NREGION), .RGN_W(RGN_W), .FILL_DATA(FILL)) u0 (.*);

   int tests = 0, fails = 0;

   // behavioural reference state
   bit [7:0]  m_en;
   bit        m_bv, m_bw, m_rv, m_rw, m_st;
   longint unsigned m_ba, m_lo, m_hi;
   int        m_br;
   longint unsigned m_bd, m_rd;

   always @(posedge clk) begin
      bit blk;
      if (!rst_n) begin
         m_en = 0; m_bv = 0; m_rv = 0; m_st = 0; m_lo = 0; m_hi = 0;
         m_bw = 0; m_ba = 0; m_br = 0; m_bd = 0; m_rw = 0; m_rd = 0;
      end else begin
         blk = req_valid && req_cacheable && (int'(req_region) < NREGION) && m_en[req_region];
         m_bv = req_valid && !blk;
         if (m_bv) begin m_bw = req_write; m_ba = req_addr; m_br = req_region; m_bd = req_wdata; end
         m_rv = blk;
         if (blk) begin m_rw = req_write; m_rd = req_write ? 0 : FILL; end
         if (blk) m_st = 1; else if (stat_rd) m_st = 0;
         if (blk && !err_lock) begin
            m_lo = req_addr & 64'hFFFF_FFFF;
            m_hi = longint'(req_addr) >> REG_W;
         end
         if (cfg_we) m_en = cfg_blk_en;
      end
   end

   task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   bit cmp_on = 0;
   always @(negedge clk) if (cmp_on) begin
      chk("R10/R3 bus_valid", bus_valid, m_bv);
      if (m_bv) begin
         chk("R10 bus_addr", bus_addr, m_ba);
         chk("R10 bus_write", bus_write, m_bw);
         chk("R10 bus_region", bus_region, m_br);
         chk("R10 bus_wdata", bus_wdata, m_bd);
      end
      chk("R4/R5 blk_rsp_valid", blk_rsp_valid, m_rv);
      if (m_rv) begin
         chk("R5 blk_rsp_write", blk_rsp_write, m_rw);
         chk("R4 blk_rsp_code", blk_rsp_code, 0);
         chk("R4 blk_rsp_data", blk_rsp_data, m_rd);
      end
      chk("R6/R7 stat_blk", stat_blk, m_st);
      chk("R8/R9 log_lo", log_lo, m_lo);
      chk("R8/R9 log_hi", log_hi, m_hi);
   end

   task automatic step(input bit v, input bit w, input bit c, input longint unsigned a,
                       input int r, input bit sr, input bit lk);
      req_valid = v; req_write = w; req_cacheable = c; req_addr = a[ADDR_W-1:0];
      req_region = r[RGN_W-1:0]; req_wdata = $urandom; stat_rd = sr; err_lock = lk;
      @(negedge clk);
      req_valid = 0; stat_rd = 0; cfg_we = 0;
   endtask

   task automatic load_en(input bit [7:0] e);
      cfg_we = 1; cfg_blk_en = e;
      @(negedge clk);
      cfg_we = 0;
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1;
            @(negedge clk);
            // R11 reset state
            chk("R11 bus_valid", bus_valid, 0);
            chk("R11 blk_rsp_valid", blk_rsp_valid, 0);
            chk("R11 stat_blk", stat_blk, 0);
            chk("R11 log", {log_hi, log_lo}, 0);
            cmp_on = 1;
            // R2: default enables zero, cacheable passes
            step(1, 0, 1, 64'h12_3456_7890, 0, 0, 0);
            @(negedge clk);
            chk("R2 default pass", stat_blk, 0);
            load_en(8'b0000_0101);
            // R1/R4 blocked read, region 0
            step(1, 0, 1, 64'hAB_CDEF_0123, 0, 0, 0);
            chk("R4 blocked read ack", blk_rsp_valid, 1);
            chk("R8 log_hi", log_hi, 32'hAB);
            // R1 uncached to enabled region passes
            step(1, 0, 0, 64'h11_0000_0004, 0, 0, 0);
            chk("R1 uncached passes", bus_valid, 1);
            // R1 cacheable to disabled region passes
            step(1, 1, 1, 64'h22_0000_0008, 1, 0, 0);
            chk("R1 other region passes", bus_valid, 1);
            // R5 blocked write
            step(1, 1, 1, 64'h33_0000_0010, 2, 0, 0);
            chk("R5 write ack", blk_rsp_write, 1);
            // R6 read clears
            step(0, 0, 0, 0, 0, 1, 0);
            chk("R6 cleared", stat_blk, 0);
            // R7 same cycle set wins
            step(1, 0, 1, 64'h44_0000_0020, 2, 1, 0);
            chk("R7 set wins", stat_blk, 1);
            // R9 locked log holds
            step(1, 0, 1, 64'h55_0000_0040, 0, 0, 1);
            chk("R9 locked hold", log_lo, 32'h0000_0020);
            // R2 same-cycle reload uses old enables
            cfg_we = 1; cfg_blk_en = 8'h00;
            step(1, 0, 1, 64'h66_0000_0080, 0, 0, 0);
            chk("R2 old enables", blk_rsp_valid, 1);
            step(1, 0, 1, 64'h77_0000_0100, 0, 0, 0);
            chk("R2 new enables", bus_valid, 1);
            // random phase
            for (int i = 0; i < 3000; i++) begin
               if ($urandom_range(0, 15) == 0) begin cfg_we = 1; cfg_blk_en = 8'($urandom); end
               step($urandom_range(0, 3) != 0, 1'($urandom), 1'($urandom),
                    {$urandom, $urandom}, $urandom_range(0, 7),
                    $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0);
            end
            cmp_on = 0;
         end
         begin
            repeat (100000) @(posedge clk);
            tests++; fails++;
            $display("FAIL watchdog expired");
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule